// File: doc/BRIEF.md
# SMRAM Window Decoder and Remapper

This block looks at every memory request on the system side and decides whether the request falls into one of three protected system-management memory windows. The three windows are a fixed legacy window low in the address map, a fixed alias window high in the 4 GB space, and a segment of variable size carved from the top of installed DRAM. For each request it gives a verdict: a hit that is allowed, a hit that is refused, or a miss that must be routed to the rest of the decode. It also gives the physical DRAM address to use.

The alias window holds no DRAM of its own. It is folded down onto the same DRAM as the legacy window. The legacy window and the top segment map one to one: their DRAM address is the bus address. Only the processor may reach a window, and only while it runs in management mode. A software-set open bit relaxes the mode rule for the legacy window alone. The verdict and the address are registered and appear one clock after the request.

Top module: `smm_window_map`

## Requirements
- R1: A synchronous reset drives every output to zero.
- R2: In the cycle after a clock edge that samples `reqValid` high, `rspValid` is 1 and the verdict belongs to that request. After an edge that samples `reqValid` low, every output is 0 in the next cycle.
- R3: With `enLow` set, bus addresses 0xA0000 through 0xBFFFF hit. For these addresses the DRAM address equals the bus address.
- R4: With `enHigh` set, bus addresses 0xFEDA0000 through 0xFEDBFFFF hit and are translated to DRAM 0xA0000 through 0xBFFFF, keeping the offset. Addresses from 0xFEDC0000 up and addresses below 0xFEDA0000 do not hit this window.
- R5: With `enTop` set, the segment spans `[topOfMem - size, topOfMem)`. The lower bound is inclusive and the upper bound is exclusive. `segSizeSel` selects the size: 00 = 128 KB, 01 = 256 KB, 10 = 512 KB, 11 = 1 MB. Addresses in the segment are not translated. If `topOfMem` is below the size, the segment is empty.
- R6: `reqSrc` encodes the requesting master: 00 = processor, 01 = I/O hub, 10 = graphics port, 11 = other. Any master other than the processor that hits a window gets `rspHit`=1 and `rspDeny`=1.
- R7: A processor hit while `smmActive` is 0 is denied. The one exception is a hit in the legacy window while `lowOpen` is 1, which is allowed. A processor hit while `smmActive` is 1 is allowed.
- R8: A window whose enable bit is 0 never hits, even for an address inside its range.
- R9: A miss gives `rspRouteOut`=1 with `rspHit`, `rspAllow` and `rspDeny` at 0, and the DRAM address equal to the bus address. For every valid response, exactly one of `rspAllow`, `rspDeny` and `rspRouteOut` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | 36 | Bus address of the request |
| reqSrc | input | 2 | Master tag: 00 processor, 01 I/O hub, 10 graphics, 11 other |
| smmActive | input | 1 | Processor is in management mode |
| enLow | input | 1 | Enable for the legacy window |
| enHigh | input | 1 | Enable for the high alias window |
| enTop | input | 1 | Enable for the top-of-memory segment |
| lowOpen | input | 1 | Legacy window open to the processor outside management mode |
| topOfMem | input | 36 | Top of DRAM, 1 MB aligned |
| segSizeSel | input | 2 | Segment size select |
| rspValid | output | 1 | Response valid |
| rspHit | output | 1 | Request hit a window |
| rspAllow | output | 1 | Hit granted |
| rspDeny | output | 1 | Hit refused |
| rspRouteOut | output | 1 | Miss, route to other decode |
| rspDramAddr | output | 36 | DRAM address to use |

## Verification
A wrong window comparison shows up one cycle after the request as a flipped `rspRouteOut`. A boundary error shows up only on the first or last address of a window, so the bench probes both edges of each window and the address just outside each edge. A broken alias subtraction leaves `rspHit` correct but puts a wrong `rspDramAddr` in that same cycle. A faulty master or mode qualification swaps `rspAllow` and `rspDeny`. The directed cases isolate each of these by changing one input at a time.

// File: rtl/smm_map_pkg.sv
package smm_map_pkg;
  localparam int ADDR_W        = 36;
  localparam int SEL_W         = 2;
  localparam int SEG_MIN_SHIFT = 17;  // 128 KB smallest segment

  localparam logic [ADDR_W-1:0] LOW_FIRST  = 36'h0_000A_0000;
  localparam logic [ADDR_W-1:0] LOW_LAST   = 36'h0_000B_FFFF;
  localparam logic [ADDR_W-1:0] HIGH_FIRST = 36'h0_FEDA_0000;
  localparam logic [ADDR_W-1:0] HIGH_LAST  = 36'h0_FEDB_FFFF;
  localparam logic [ADDR_W-1:0] ALIAS_DELTA = HIGH_FIRST - LOW_FIRST;

  typedef enum logic [1:0] {
    SRC_CPU   = 2'b00,
    SRC_IOHUB = 2'b01,
    SRC_GFX   = 2'b10,
    SRC_OTHER = 2'b11
  } srcTag_t;

  typedef struct packed {
    logic capture;
    logic hit;
    logic allow;
    logic deny;
    logic remapHigh;
  } mapStrobe_t;
endpackage

// File: rtl/smm_map_ctrl.sv
module smm_map_ctrl
  import smm_map_pkg::*;
(
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSrc,
  input  logic              smmActive,
  input  logic              enLow,
  input  logic              enHigh,
  input  logic              enTop,
  input  logic              lowOpen,
  input  logic [ADDR_W-1:0] topOfMem,
  input  logic [SEL_W-1:0]  segSizeSel,
  output mapStrobe_t        strobe
);
  logic [ADDR_W-1:0] segSize;
  logic [ADDR_W-1:0] segBase;
  logic segNonEmpty, lowHit, highHit, topHit, anyHit, isCpu, modeOk;

  always_comb begin
    segSize     = ADDR_W'(1) << (SEG_MIN_SHIFT + int'(segSizeSel));
    segBase     = topOfMem - segSize;
    segNonEmpty = topOfMem >= segSize;
    lowHit  = enLow  && (reqAddr >= LOW_FIRST)  && (reqAddr <= LOW_LAST);
    highHit = enHigh && (reqAddr >= HIGH_FIRST) && (reqAddr <= HIGH_LAST);
    topHit  = enTop  && segNonEmpty && (reqAddr >= segBase) && (reqAddr < topOfMem);
    anyHit  = lowHit || highHit || topHit;
    isCpu   = reqSrc == SRC_CPU;
    modeOk  = smmActive || (lowHit && lowOpen);

    strobe.capture   = reqValid;
    strobe.hit       = anyHit;
    strobe.allow     = anyHit && isCpu && modeOk;
    strobe.deny      = anyHit && !(isCpu && modeOk);
    strobe.remapHigh = highHit && !lowHit;
  end
endmodule

// File: rtl/smm_map_dp.sv
module smm_map_dp
  import smm_map_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  mapStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addrIn,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspAllow,
  output logic              rspDeny,
  output logic              rspRouteOut,
  output logic [ADDR_W-1:0] rspDramAddr
);
  logic [ADDR_W-1:0] xlatAddr;

  always_comb xlatAddr = strobe.remapHigh ? (addrIn - ALIAS_DELTA) : addrIn;

  always_ff @(posedge clk) begin
    if (rst || !strobe.capture) begin
      rspValid    <= 1'b0;
      rspHit      <= 1'b0;
      rspAllow    <= 1'b0;
      rspDeny     <= 1'b0;
      rspRouteOut <= 1'b0;
      rspDramAddr <= '0;
    end else begin
      rspValid    <= 1'b1;
      rspHit      <= strobe.hit;
      rspAllow    <= strobe.allow;
      rspDeny     <= strobe.deny;
      rspRouteOut <= !strobe.hit;
      rspDramAddr <= xlatAddr;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> !rspValid && !rspHit && !rspAllow && !rspDeny && !rspRouteOut && rspDramAddr == '0);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !rspValid |-> !rspHit && !rspAllow && !rspDeny && !rspRouteOut);

  assert_one_verdict_R9: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> $onehot({rspAllow, rspDeny, rspRouteOut}));

  assert_miss_passthrough_R9: assert property (@(posedge clk) disable iff (rst)
    (strobe.capture && !strobe.hit) |=> rspDramAddr == $past(addrIn));
endmodule

// File: rtl/smm_window_map.sv
module smm_window_map
  import smm_map_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [35:0]       reqAddr,
  input  logic [1:0]        reqSrc,
  input  logic              smmActive,
  input  logic              enLow,
  input  logic              enHigh,
  input  logic              enTop,
  input  logic              lowOpen,
  input  logic [35:0]       topOfMem,
  input  logic [1:0]        segSizeSel,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspAllow,
  output logic              rspDeny,
  output logic              rspRouteOut,
  output logic [35:0]       rspDramAddr
);
  mapStrobe_t strobe;

  smm_map_ctrl u_ctrl (
    .reqValid(reqValid), .reqAddr(reqAddr), .reqSrc(reqSrc),
    .smmActive(smmActive), .enLow(enLow), .enHigh(enHigh), .enTop(enTop),
    .lowOpen(lowOpen), .topOfMem(topOfMem), .segSizeSel(segSizeSel),
    .strobe(strobe)
  );

  smm_map_dp u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .addrIn(reqAddr),
    .rspValid(rspValid), .rspHit(rspHit), .rspAllow(rspAllow),
    .rspDeny(rspDeny), .rspRouteOut(rspRouteOut), .rspDramAddr(rspDramAddr)
  );

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> rspValid);

  assert_foreign_never_allowed_R6: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqSrc != SRC_CPU) |=> !rspAllow);

  assert_high_alias_R4: assert property (@(posedge clk) disable iff (rst)
    (reqValid && enHigh && reqAddr >= HIGH_FIRST && reqAddr <= HIGH_LAST)
      |=> rspHit && rspDramAddr == $past(reqAddr) - ALIAS_DELTA);

  assert_disabled_low_R8: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !enLow && !enTop && reqAddr >= LOW_FIRST && reqAddr <= LOW_LAST)
      |=> rspRouteOut);
endmodule

// File: tb/smm_window_map_bench.sv
module smm_window_map_bench;
  logic clk = 1'b0;
  logic rst;
  logic reqValid, smmActive, enLow, enHigh, enTop, lowOpen;
  logic [35:0] reqAddr, topOfMem, rspDramAddr;
  logic [1:0] reqSrc, segSizeSel;
  logic rspValid, rspHit, rspAllow, rspDeny, rspRouteOut;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  smm_window_map u_smm_window_map (.*);

  // verdict codes: 0 miss, 1 allow, 2 deny
  task automatic expect_out(string tag, logic v, logic h, logic a, logic d, logic r,
                            logic [35:0] addr);
    checks++;
    if ({rspValid, rspHit, rspAllow, rspDeny, rspRouteOut} !== {v, h, a, d, r} ||
        rspDramAddr !== addr) begin
      errors++;
      $display("FAIL %s: got v%b h%b a%b d%b r%b addr %h, expected v%b h%b a%b d%b r%b addr %h",
               tag, rspValid, rspHit, rspAllow, rspDeny, rspRouteOut, rspDramAddr,
               v, h, a, d, r, addr);
    end
  endtask

  task automatic probe(string tag, logic [35:0] addr, logic [1:0] src, int verdict,
                       logic [35:0] dram);
    @(negedge clk);
    reqAddr = addr; reqSrc = src; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    case (verdict)
      0: expect_out(tag, 1, 0, 0, 0, 1, dram);
      1: expect_out(tag, 1, 1, 1, 0, 0, dram);
      default: expect_out(tag, 1, 1, 0, 1, 0, dram);
    endcase
  endtask

  task automatic test_reset();
    rst = 1'b1; reqValid = 1'b1; reqAddr = 36'hA0000; reqSrc = 2'b00;
    smmActive = 1'b1; enLow = 1'b1; enHigh = 1'b1; enTop = 1'b1; lowOpen = 1'b0;
    topOfMem = 36'h0_4000_0000; segSizeSel = 2'b00;
    repeat (3) @(negedge clk);
    expect_out("R1 reset", 0, 0, 0, 0, 0, 36'h0);
    reqValid = 1'b0; rst = 1'b0;
    @(negedge clk);
    expect_out("R2 idle", 0, 0, 0, 0, 0, 36'h0);
  endtask

  task automatic test_low();
    probe("R3 low first", 36'h0_000A_0000, 2'b00, 1, 36'h0_000A_0000);
    probe("R3 low last",  36'h0_000B_FFFF, 2'b00, 1, 36'h0_000B_FFFF);
    probe("R3 below low", 36'h0_0009_FFFF, 2'b00, 0, 36'h0_0009_FFFF);
    probe("R3 above low", 36'h0_000C_0000, 2'b00, 0, 36'h0_000C_0000);
    @(negedge clk);
    expect_out("R2 gap after request", 0, 0, 0, 0, 0, 36'h0);
  endtask

  task automatic test_high();
    probe("R4 high first", 36'h0_FEDA_0000, 2'b00, 1, 36'h0_000A_0000);
    probe("R4 high mid",   36'h0_FEDA_1234, 2'b00, 1, 36'h0_000A_1234);
    probe("R4 high last",  36'h0_FEDB_FFFF, 2'b00, 1, 36'h0_000B_FFFF);
    probe("R4 old upper",  36'h0_FEDC_0000, 2'b00, 0, 36'h0_FEDC_0000);
    probe("R4 old top",    36'h0_FEDF_FFFF, 2'b00, 0, 36'h0_FEDF_FFFF);
    probe("R4 below high", 36'h0_FED9_FFFF, 2'b00, 0, 36'h0_FED9_FFFF);
  endtask

  task automatic test_top();
    topOfMem = 36'h0_4000_0000;
    segSizeSel = 2'b00;
    probe("R5 128K base",   36'h0_3FFE_0000, 2'b00, 1, 36'h0_3FFE_0000);
    probe("R5 128K under",  36'h0_3FFD_FFFF, 2'b00, 0, 36'h0_3FFD_FFFF);
    probe("R5 128K last",   36'h0_3FFF_FFFF, 2'b00, 1, 36'h0_3FFF_FFFF);
    probe("R5 at TOM",      36'h0_4000_0000, 2'b00, 0, 36'h0_4000_0000);
    segSizeSel = 2'b01;
    probe("R5 256K base",   36'h0_3FFC_0000, 2'b00, 1, 36'h0_3FFC_0000);
    probe("R5 256K under",  36'h0_3FFB_FFFF, 2'b00, 0, 36'h0_3FFB_FFFF);
    segSizeSel = 2'b10;
    probe("R5 512K base",   36'h0_3FF8_0000, 2'b00, 1, 36'h0_3FF8_0000);
    segSizeSel = 2'b11;
    probe("R5 1M base",     36'h0_3FF0_0000, 2'b00, 1, 36'h0_3FF0_0000);
    probe("R5 1M under",    36'h0_3FEF_FFFF, 2'b00, 0, 36'h0_3FEF_FFFF);
    topOfMem = 36'h8_0000_0000;
    probe("R5 high TOM",    36'h7_FFF0_0000, 2'b00, 1, 36'h7_FFF0_0000);
    topOfMem = 36'h0;
    segSizeSel = 2'b00;
    probe("R5 empty seg",   36'hF_FFFE_0000, 2'b00, 0, 36'hF_FFFE_0000);
    topOfMem = 36'h0_4000_0000;
  endtask

  task automatic test_masters();
    probe("R6 hub low",     36'h0_000A_0000, 2'b01, 2, 36'h0_000A_0000);
    probe("R6 gfx top",     36'h0_3FFE_0000, 2'b10, 2, 36'h0_3FFE_0000);
    probe("R6 other high",  36'h0_FEDA_0010, 2'b11, 2, 36'h0_000A_0010);
    probe("R6 hub miss",    36'h0_0010_0000, 2'b01, 0, 36'h0_0010_0000);
  endtask

  task automatic test_mode();
    smmActive = 1'b0; lowOpen = 1'b0;
    probe("R7 low closed",  36'h0_000A_0000, 2'b00, 2, 36'h0_000A_0000);
    lowOpen = 1'b1;
    probe("R7 low open",    36'h0_000A_0000, 2'b00, 1, 36'h0_000A_0000);
    probe("R7 high open",   36'h0_FEDA_0000, 2'b00, 2, 36'h0_000A_0000);
    probe("R7 top open",    36'h0_3FFE_0000, 2'b00, 2, 36'h0_3FFE_0000);
    probe("R7 hub open",    36'h0_000A_0000, 2'b01, 2, 36'h0_000A_0000);
    smmActive = 1'b1; lowOpen = 1'b0;
  endtask

  task automatic test_enables();
    enLow = 1'b0;
    probe("R8 low off",  36'h0_000A_0000, 2'b00, 0, 36'h0_000A_0000);
    probe("R8 high on",  36'h0_FEDA_0000, 2'b00, 1, 36'h0_000A_0000);
    enHigh = 1'b0;
    probe("R8 high off", 36'h0_FEDA_0000, 2'b00, 0, 36'h0_FEDA_0000);
    enTop = 1'b0;
    probe("R8 top off",  36'h0_3FFE_0000, 2'b00, 0, 36'h0_3FFE_0000);
    probe("R9 hub miss off", 36'h0_000B_0000, 2'b01, 0, 36'h0_000B_0000);
    enLow = 1'b1; enHigh = 1'b1; enTop = 1'b1;
  endtask

  initial begin
    test_reset();
    test_low();
    test_high();
    test_top();
    test_masters();
    test_mode();
    test_enables();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule